// File: doc/BRIEF.md
# CAN Frame Timestamp Timer

This block is the time base of a CAN controller. A 16-bit counter advances by one on every clock in which a prescaled tick input is high. Software reaches it through a small register port. The counter wraps at its top value, and it can also restart from a programmable offset when it equals a compare value. The other parts of the controller show up here only as single-cycle strobes: a start-of-frame pulse and a received-ID-hit pulse.

On each start-of-frame, whether the node sends or receives, the running count is copied into a capture register. This gives every frame a timestamp. A receive-ID hit can disarm capture automatically, which freezes the timestamp of that frame. When software clears the enable bit, the counter does not stop at once. It runs on to the end of its current cycle, clears to zero there and then halts.

Top module: `can_tstamp_timer`

## Requirements
- R1: After reset the counter, control, compare, offset and capture registers all read 0, and both strobes are low.
- R2: Register map: address 0 is the counter (read/write), 1 is control, 2 is compare, 3 is offset and 4 is capture (read-only). A write to the counter shows on the next clock and takes priority over any increment or reload in the same clock.
- R3: The counter changes only on a clock where tick_en is high and the timer is running. Running means control bit 15 is 1, or a stop is still pending (see R6). In that case it adds 1.
- R4: On a counting clock at 0xFFFF the counter wraps to 0x0000, and ovf_strobe is high for exactly the following cycle.
- R5: On a counting clock where the counter equals the compare register, cmp_strobe is high for the following cycle. If control bit 11 is 1 the counter loads the offset register, otherwise it just adds 1.
- R6: Writing control bit 15 from 1 to 0 does not stop the counter at once. It keeps counting until the next wrap or compare match. On that clock it becomes 0, and it then holds.
- R7: While control bit 14 is 1, a sof_pulse copies the counter value of that clock into the capture register. Writes to address 4 are ignored.
- R8: While control bit 14 is 0, the capture register holds its value through any sof_pulse.
- R9: If control bit 9 is 1, rx_id_hit clears control bit 14. A sof_pulse in the same clock still captures. With bit 9 at 0, rx_id_hit has no effect.
- R10: Control bits 8 and 6 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational on reg_addr) |
| tick_en | input | 1 | Prescaled count enable |
| sof_pulse | input | 1 | Start-of-frame seen on the bus |
| rx_id_hit | input | 1 | Received ID matched a capture-flagged mailbox |
| cmp_strobe | output | 1 | One-cycle compare-match pulse |
| ovf_strobe | output | 1 | One-cycle wrap pulse |

## Verification
Several properties are checked on every cycle:
- the capture register either samples the count at a start-of-frame or holds;
- a counter write always lands;
- an idle timer never moves;
- each strobe traces back to a wrap or compare condition;
- the hardware disarm clears the capture enable.

Some behaviour depends on a history of many cycles, and only the bench scenarios can show it. This covers the graceful stop finishing its cycle before clearing, the reload sequences against an arithmetic model over swept offsets and tick counts, and the wrap arithmetic across many starting points.

// File: rtl/can_tstamp_timer.sv
module can_tstamp_timer #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          tick_en,
  input  logic          sof_pulse,
  input  logic          rx_id_hit,
  output logic          cmp_strobe,
  output logic          ovf_strobe
);
  localparam logic [AW-1:0] A_CNT = AW'(0);
  localparam logic [AW-1:0] A_CTL = AW'(1);
  localparam logic [AW-1:0] A_CMP = AW'(2);
  localparam logic [AW-1:0] A_OFF = AW'(3);
  localparam logic [AW-1:0] A_CAP = AW'(4);
  localparam int B_EN  = 15;
  localparam int B_CAP = 14;
  localparam int B_RLD = 11;
  localparam int B_ARM = 9;
  localparam logic [DW-1:0] CTL_MASK = ~(DW'(1) << 8 | DW'(1) << 6);

  logic [DW-1:0] cnt_q, cnt_d, cmp_q, off_q, ctl_q, cap_q;
  logic          run_q;

  wire wr_cnt  = reg_wr && reg_addr == A_CNT;
  wire wr_ctl  = reg_wr && reg_addr == A_CTL;
  wire go      = ctl_q[B_EN] | run_q;
  wire step    = go & tick_en;
  wire hit_cmp = step && cnt_q == cmp_q;
  wire hit_top = step && cnt_q == {DW{1'b1}};
  wire cyc_end = hit_cmp | hit_top;

  always_comb begin
    if (wr_cnt)                         cnt_d = reg_wdata;
    else if (cyc_end && !ctl_q[B_EN])   cnt_d = '0;
    else if (hit_cmp && ctl_q[B_RLD])   cnt_d = off_q;
    else if (step)                      cnt_d = cnt_q + DW'(1);
    else                                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      cmp_q      <= '0;
      off_q      <= '0;
      ctl_q      <= '0;
      cap_q      <= '0;
      run_q      <= 1'b0;
      cmp_strobe <= 1'b0;
      ovf_strobe <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      run_q      <= ctl_q[B_EN] | (run_q & ~cyc_end);
      cmp_strobe <= hit_cmp;
      ovf_strobe <= hit_top;
      if (reg_wr && reg_addr == A_CMP) cmp_q <= reg_wdata;
      if (reg_wr && reg_addr == A_OFF) off_q <= reg_wdata;
      if (wr_ctl)                              ctl_q <= reg_wdata & CTL_MASK;
      else if (ctl_q[B_ARM] && rx_id_hit)      ctl_q[B_CAP] <= 1'b0;
      if (ctl_q[B_CAP] && sof_pulse) cap_q <= cnt_q;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CNT:   reg_rdata = cnt_q;
      A_CTL:   reg_rdata = ctl_q;
      A_CMP:   reg_rdata = cmp_q;
      A_OFF:   reg_rdata = off_q;
      A_CAP:   reg_rdata = cap_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/can_tstamp_timer_chk.sv
module can_tstamp_timer_chk #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          sof_pulse,
  input logic          rx_id_hit,
  input logic          cmp_strobe,
  input logic          ovf_strobe,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] cmp,
  input logic [DW-1:0] ctl,
  input logic [DW-1:0] cap,
  input logic          run
);
  wire wr_cnt = reg_wr && reg_addr == AW'(0);
  wire wr_ctl = reg_wr && reg_addr == AW'(1);

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(reg_wdata)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl[15] && !run && !wr_cnt) |=> $stable(cnt)); // R3
  AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_strobe |-> $past(cnt) == {DW{1'b1}}); // R4
  AST_CMP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> $past(cnt) == $past(cmp)); // R5
  AST_CAP_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[14] && sof_pulse) |=> cap == $past(cnt)); // R7
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl[14] && sof_pulse) |=> $stable(cap)); // R8
  AST_AUTO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[9] && rx_id_hit && !wr_ctl) |=> !ctl[14]); // R9
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'(1) |-> (reg_rdata[8] == 1'b0 && reg_rdata[6] == 1'b0)); // R10
endmodule

bind can_tstamp_timer can_tstamp_timer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sof_pulse(sof_pulse),
  .rx_id_hit(rx_id_hit), .cmp_strobe(cmp_strobe), .ovf_strobe(ovf_strobe),
  .cnt(cnt_q), .cmp(cmp_q), .ctl(ctl_q), .cap(cap_q), .run(run_q)
);

// File: tb/can_tstamp_timer_test.sv
module can_tstamp_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, tick = 1'b0, sof = 1'b0, idh = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic cmps, ovfs;
  int n_cmp = 0, n_bad = 0, cmp_seen = 0, ovf_seen = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  can_tstamp_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .tick_en(tick), .sof_pulse(sof), .rx_id_hit(idh),
    .cmp_strobe(cmps), .ovf_strobe(ovfs)
  );

  always @(negedge clk) begin
    if (cmps) cmp_seen++;
    if (ovfs) ovf_seen++;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [15:0] d);
    wr = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    addr = 3'(a);
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] model(input logic [15:0] x0, input logic [15:0] c,
                                        input logic [15:0] o, input int k, input bit sel);
    logic [15:0] x = x0;
    for (int i = 0; i < k; i++) x = (sel && x == c) ? o : x + 16'd1;
    return x;
  endfunction

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c, v0;
    logic [15:0] offs [4] = '{16'h0000, 16'h0010, 16'h0100, 16'hFFF0};
    idle(3);
    rst_n = 1'b1;
    idle(1);
    for (int a = 0; a < 5; a++) begin rd(a, v); chk("R1 reg", v, 16'h0); end
    chk("R1 strobes", {14'b0, cmps, ovfs}, 16'h0);

    wr_reg(0, 16'h1234); rd(0, v); chk("R2 counter write", v, 16'h1234);
    tick = 1'b1; idle(5); rd(0, v); chk("R3 disabled hold", v, 16'h1234);
    tick = 1'b0; wr_reg(1, 16'h8000); idle(4); rd(0, v); chk("R3 no tick hold", v, 16'h1234);

    for (int k = 1; k <= 12; k++) begin
      v0 = 16'h2000 + 16'(k * 16'h111);
      wr_reg(0, v0); tick = 1'b1; idle(k); tick = 1'b0;
      rd(0, v); chk("R3 tick count", v, v0 + 16'(k));
    end
    wr_reg(0, 16'h3000);
    for (int i = 0; i < 21; i++) begin tick = (i % 3 == 0); idle(1); end
    tick = 1'b0; rd(0, v); chk("R3 sparse ticks", v, 16'h3007);

    for (int s = 1; s <= 8; s++) begin
      wr_reg(0, 16'(17'h10000 - s)); ovf_seen = 0;
      tick = 1'b1; idle(s + 3); tick = 1'b0;
      rd(0, v); chk("R4 wrap value", v, 16'h0003);
      chk("R4 ovf pulses", 16'(ovf_seen), 16'h1);
    end

    c = 16'h0040;
    wr_reg(2, c); wr_reg(1, 16'h8800);
    for (int oi = 0; oi < 4; oi++) begin
      wr_reg(3, offs[oi]);
      for (int k = 1; k <= 8; k++) begin
        wr_reg(0, c - 16'd2); cmp_seen = 0;
        tick = 1'b1; idle(k); tick = 1'b0;
        rd(0, v); chk("R5 reload", v, model(c - 16'd2, c, offs[oi], k, 1'b1));
        chk("R5 cmp pulses", 16'(cmp_seen), (k >= 3) ? 16'h1 : 16'h0);
      end
    end
    wr_reg(1, 16'h8000); wr_reg(0, c - 16'd2);
    tick = 1'b1; idle(6); tick = 1'b0;
    rd(0, v); chk("R5 no reload", v, model(c - 16'd2, c, 16'h0010, 6, 1'b0));

    wr_reg(1, 16'h8800); tick = 1'b1;
    wr_reg(0, c - 16'd1); idle(1); cmp_seen = 0;
    wr_reg(0, 16'h7777); tick = 1'b0;
    rd(0, v); chk("R2 write beats reload", v, 16'h7777);
    chk("R2 cmp still seen", 16'(cmp_seen), 16'h1);

    wr_reg(1, 16'h8000); wr_reg(2, 16'h0100); wr_reg(0, 16'h00F0);
    tick = 1'b1; idle(2); wr_reg(1, 16'h0000); idle(4);
    rd(0, v); chk("R6 still counting", v, 16'h00F7);
    idle(20); rd(0, v); chk("R6 cleared at match", v, 16'h0000);
    idle(5); rd(0, v); chk("R6 stays halted", v, 16'h0000);
    tick = 1'b0; wr_reg(1, 16'h8000); wr_reg(0, 16'hFFF8); ovf_seen = 0;
    tick = 1'b1; wr_reg(1, 16'h0000); idle(20);
    rd(0, v); chk("R6 cleared at wrap", v, 16'h0000);
    chk("R6 one wrap", 16'(ovf_seen), 16'h1);

    tick = 1'b0; wr_reg(1, 16'hC000); wr_reg(0, 16'h0500); tick = 1'b1;
    for (int i = 0; i < 6; i++) begin
      idle(i + 1); rd(0, v); sof = 1'b1; @(negedge clk); sof = 1'b0;
      rd(4, c); chk("R7 capture", c, v);
    end
    wr_reg(4, 16'h5555); rd(4, c); chk("R7 capture read-only", c, v);

    wr_reg(1, 16'h8000);
    for (int i = 0; i < 3; i++) begin sof = 1'b1; idle(1); sof = 1'b0; idle(2); end
    rd(4, c); chk("R8 capture holds", c, v);

    wr_reg(1, 16'hC200); idle(2);
    rd(0, v); sof = 1'b1; idh = 1'b1; @(negedge clk); sof = 1'b0; idh = 1'b0;
    rd(4, c); chk("R9 same-clock capture", c, v);
    rd(1, c); chk("R9 capture disarmed", c, 16'h8200);
    idle(2); sof = 1'b1; idle(1); sof = 1'b0;
    rd(4, c); chk("R9 frozen stamp", c, v);
    wr_reg(1, 16'hC000); idh = 1'b1; idle(1); idh = 1'b0;
    rd(1, c); chk("R9 hit ignored unarmed", c, 16'hC000);

    tick = 1'b0; wr_reg(1, 16'hFFFF); rd(1, c); chk("R10 reserved bits", c, 16'hFEBF);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule